// File: doc/BRIEF.md
# Synchronous DRAM Command Decoder and Bank Tracker

This block sits on the device side of a synchronous DRAM interface. On every rising clock edge it samples the clock-enable, chip-select, the three command strobes, the bank address, the address bus and the data mask. It turns them into one registered command pulse, keeps an open/closed flag and the open row for each bank, and holds the mode and extended mode registers. It also produces the write mask and the read output enable at the latencies the mask pin requires.

A small power-mode state machine follows the clock-enable pin. It has four states: `PM_RUN` (code 0), `PM_PDOWN` (code 1, power-down), `PM_SUSP` (code 2, clock suspend) and `PM_SREF` (code 3, self-refresh).
- The entry transitions leave `PM_RUN` when clock-enable is sampled low. A NOP or deselect goes to `PM_PDOWN` when every bank is closed and to `PM_SUSP` otherwise. A refresh command goes to `PM_SREF` when every bank is closed. Any other command goes to `PM_SUSP`.
- The exit transition returns any low-power state to `PM_RUN` when clock-enable is sampled high again.

Commands that break the bank rules are refused. They set a sticky error flag.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: Commands are decoded from {ras_n,cas_n,we_n}: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode load, 110 burst stop, 111 NOP. An accepted command raises exactly one matching strobe in the cycle after its sampling edge. In that same cycle cmd_bank shows ba, cmd_col shows addr[7:0] and cmd_ap shows addr[8]; these fields hold their values between accepted commands.
- R2: While cs_n is high no strobe is raised and no bank, row or mode register changes.
- R3: Activate to a closed bank opens it and stores addr[10:0] as that bank's row, shown in open_rows[11*b +: 11].
- R4: Read or write to an open bank is accepted. With addr[8] high, the bank is closed after that access.
- R5: Precharge with addr[8] low closes only the addressed bank; with addr[8] high it closes all four.
- R6: A mode load with ba=0 writes addr into mode_reg and with ba=1 into ext_mode_reg; ba=2 or 3 changes neither.
- R7: wr_mask equals dqm in the same cycle (zero latency).
- R8: rd_oe is the inverse of dqm delayed two cycles. It is delayed one cycle when ext_mode_reg[0] is 1 and the CAS latency field mode_reg[6:4] is 1.
- R9: With clock-enable sampled low in PM_RUN, pwr_mode follows the entry rules above, and the command presented is not executed.
- R10: In a low-power state, commands are ignored. Clock-enable sampled high returns pwr_mode to 0. If anything other than NOP or deselect is presented at that exit, illegal is set.
- R11: Activate to an open bank, or read/write to a closed bank, sets illegal, raises no strobe and leaves bank state unchanged.
- R12: Refresh, whether for auto-refresh or self-refresh entry, is accepted only with all banks closed. Otherwise it sets illegal, and at clock-enable low it enters PM_SUSP.
- R13: Reset clears all strobes, banks, rows, mode registers, illegal and rd_oe, and sets pwr_mode to 0. illegal stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write enable |
| ba | input | 2 | Bank address |
| addr | input | 11 | Address bus |
| dqm | input | 1 | Data mask |
| cmd_act | output | 1 | Activate accepted |
| cmd_rd | output | 1 | Read accepted |
| cmd_wr | output | 1 | Write accepted |
| cmd_pre | output | 1 | Precharge accepted |
| cmd_ref | output | 1 | Refresh accepted |
| cmd_lmr | output | 1 | Mode load accepted |
| cmd_bst | output | 1 | Burst stop accepted |
| cmd_bank | output | 2 | Bank of last accepted command |
| cmd_col | output | 8 | Column of last accepted command |
| cmd_ap | output | 1 | Auto/all precharge bit of last accepted command |
| bank_open | output | 4 | Open flag per bank |
| open_rows | output | 44 | Open row per bank, 11 bits each |
| mode_reg | output | 11 | Mode register |
| ext_mode_reg | output | 11 | Extended mode register |
| wr_mask | output | 1 | Write data mask |
| rd_oe | output | 1 | Read output enable |
| pwr_mode | output | 2 | Power state code |
| illegal | output | 1 | Sticky illegal-command flag |

## Verification
The bench builds the block with its default parameters: four banks, 11-bit rows, 8-bit columns and the auto-precharge bit at position 8. With these values every bank can be opened, reopened and closed, both singly and all at once, within a few commands. Random command streams therefore hit the illegal activate, read, write and refresh cases often. The one-cycle read-enable path is reached by loading a CAS latency of 1 and setting the extended option bit. Random clock-enable drops then visit all three low-power states from both idle and open-bank conditions.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
    typedef enum logic [2:0] {
        C_LMR = 3'b000,
        C_REF = 3'b001,
        C_PRE = 3'b010,
        C_ACT = 3'b011,
        C_WR  = 3'b100,
        C_RD  = 3'b101,
        C_BST = 3'b110,
        C_NOP = 3'b111
    } cmd_e;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_PDOWN = 2'd1,
        PM_SUSP  = 2'd2,
        PM_SREF  = 2'd3
    } pm_e;
endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd,
    output logic is_nop,
    output logic is_ref
);
    always_comb begin
        cmd    = cmd_e'({ras_n, cas_n, we_n});
        is_nop = cs_n || (cmd == C_NOP);
        is_ref = !cs_n && (cmd == C_REF);
    end
endmodule

// File: rtl/sdcmd_banks.sv
module sdcmd_banks
    import sdcmd_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int ROW_W  = 11,
    parameter int AP_BIT = 8,
    localparam int BA_W  = $clog2(BANKS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   exec,
    input  cmd_e                   cmd,
    input  logic [BA_W-1:0]        ba,
    input  logic [ROW_W-1:0]       addr,
    output logic                   accept,
    output logic                   bad,
    output logic [BANKS-1:0]       open_q,
    output logic [BANKS*ROW_W-1:0] rows_flat
);
    logic [ROW_W-1:0] row_q [BANKS];

    always_comb begin
        unique case (cmd)
            C_ACT:      accept = !open_q[ba];
            C_RD, C_WR: accept = open_q[ba];
            C_REF:      accept = ~|open_q;
            default:    accept = 1'b1;
        endcase
        bad = exec && !accept;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= '0;
            for (int i = 0; i < BANKS; i++) row_q[i] <= '0;
        end else if (exec && accept) begin
            unique case (cmd)
                C_ACT: begin
                    open_q[ba] <= 1'b1;
                    row_q[ba]  <= addr;
                end
                C_RD, C_WR: if (addr[AP_BIT]) open_q[ba] <= 1'b0;
                C_PRE: begin
                    if (addr[AP_BIT]) open_q <= '0;
                    else              open_q[ba] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < BANKS; g++) begin : g_rows
        assign rows_flat[g*ROW_W +: ROW_W] = row_q[g];
    end
endmodule

// File: rtl/sdcmd_power.sv
module sdcmd_power
    import sdcmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic is_nop,
    input  logic is_ref,
    input  logic all_closed,
    output pm_e  state,
    output logic bad
);
    pm_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PM_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        bad = 1'b0;
        unique case (state)
            PM_RUN: begin
                if (!cke) begin
                    if (is_nop)      nxt = all_closed ? PM_PDOWN : PM_SUSP;
                    else if (is_ref) begin
                        nxt = all_closed ? PM_SREF : PM_SUSP;
                        bad = !all_closed;
                    end else         nxt = PM_SUSP;
                end
            end
            PM_PDOWN, PM_SUSP, PM_SREF: begin
                if (cke) begin
                    nxt = PM_RUN;
                    bad = !is_nop;
                end
            end
        endcase
    end
endmodule

// File: rtl/sdcmd_dqm.sv
module sdcmd_dqm (
    input  logic clk,
    input  logic rst_n,
    input  logic dqm,
    input  logic fast,
    output logic rd_oe
);
    logic d1, d2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d1 <= 1'b0;
            d2 <= 1'b0;
        end else begin
            d1 <= !dqm;
            d2 <= d1;
        end
    end

    assign rd_oe = fast ? d1 : d2;
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdcmd_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int ROW_W  = 11,
    parameter int COL_W  = 8,
    parameter int AP_BIT = 8,
    localparam int BA_W  = $clog2(BANKS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BA_W-1:0]        ba,
    input  logic [ROW_W-1:0]       addr,
    input  logic                   dqm,
    output logic                   cmd_act,
    output logic                   cmd_rd,
    output logic                   cmd_wr,
    output logic                   cmd_pre,
    output logic                   cmd_ref,
    output logic                   cmd_lmr,
    output logic                   cmd_bst,
    output logic [BA_W-1:0]        cmd_bank,
    output logic [COL_W-1:0]       cmd_col,
    output logic                   cmd_ap,
    output logic [BANKS-1:0]       bank_open,
    output logic [BANKS*ROW_W-1:0] open_rows,
    output logic [ROW_W-1:0]       mode_reg,
    output logic [ROW_W-1:0]       ext_mode_reg,
    output logic                   wr_mask,
    output logic                   rd_oe,
    output logic [1:0]             pwr_mode,
    output logic                   illegal
);
    cmd_e cmd;
    logic is_nop, is_ref, accept, bad_bank, bad_pm, exec, fire, fast;
    pm_e  pm;

    sdcmd_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cmd(cmd), .is_nop(is_nop), .is_ref(is_ref)
    );

    assign exec = (pm == PM_RUN) && cke && !cs_n;
    assign fire = exec && accept;

    sdcmd_banks #(.BANKS(BANKS), .ROW_W(ROW_W), .AP_BIT(AP_BIT)) u_banks (
        .clk(clk), .rst_n(rst_n), .exec(exec), .cmd(cmd), .ba(ba),
        .addr(addr), .accept(accept), .bad(bad_bank),
        .open_q(bank_open), .rows_flat(open_rows)
    );

    sdcmd_power u_pm (
        .clk(clk), .rst_n(rst_n), .cke(cke), .is_nop(is_nop),
        .is_ref(is_ref), .all_closed(~|bank_open), .state(pm), .bad(bad_pm)
    );

    assign fast = ext_mode_reg[0] && (mode_reg[6:4] == 3'd1);

    sdcmd_dqm u_dqm (
        .clk(clk), .rst_n(rst_n), .dqm(dqm), .fast(fast), .rd_oe(rd_oe)
    );

    assign wr_mask  = dqm;
    assign pwr_mode = pm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_lmr, cmd_bst} <= '0;
            cmd_bank     <= '0;
            cmd_col      <= '0;
            cmd_ap       <= 1'b0;
            mode_reg     <= '0;
            ext_mode_reg <= '0;
            illegal      <= 1'b0;
        end else begin
            cmd_act <= fire && (cmd == C_ACT);
            cmd_rd  <= fire && (cmd == C_RD);
            cmd_wr  <= fire && (cmd == C_WR);
            cmd_pre <= fire && (cmd == C_PRE);
            cmd_ref <= fire && (cmd == C_REF);
            cmd_lmr <= fire && (cmd == C_LMR);
            cmd_bst <= fire && (cmd == C_BST);
            if (fire && (cmd != C_NOP)) begin
                cmd_bank <= ba;
                cmd_col  <= addr[COL_W-1:0];
                cmd_ap   <= addr[AP_BIT];
            end
            if (fire && (cmd == C_LMR)) begin
                if (ba == BA_W'(0)) mode_reg     <= addr;
                if (ba == BA_W'(1)) ext_mode_reg <= addr;
            end
            illegal <= illegal || bad_bank || bad_pm;
        end
    end
endmodule

// File: rtl/sdcmd_tracker_chk.sv
module sdcmd_tracker_chk #(
    parameter int BANKS = 4,
    localparam int BA_W = $clog2(BANKS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             cmd_act,
    input logic             cmd_rd,
    input logic             cmd_wr,
    input logic             cmd_pre,
    input logic             cmd_ref,
    input logic             cmd_lmr,
    input logic             cmd_bst,
    input logic [BA_W-1:0]  cmd_bank,
    input logic             cmd_ap,
    input logic [BANKS-1:0] bank_open,
    input logic [1:0]       pwr_mode,
    input logic             illegal
);
    logic [6:0] stb;
    assign stb = {cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_lmr, cmd_bst};

    a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb));
    a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (stb == 7'd0));
    a_r3_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_act |-> bank_open[cmd_bank]);
    a_r5_pre_all_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pre && cmd_ap) |-> (bank_open == '0));
    a_r12_ref_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ref |-> (bank_open == '0));
    a_r10_lowpower_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode != 2'd0) |-> (stb == 7'd0));
    a_r13_illegal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> illegal);
endmodule

bind sdram_cmd_tracker sdcmd_tracker_chk #(.BANKS(BANKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
    .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_pre(cmd_pre),
    .cmd_ref(cmd_ref), .cmd_lmr(cmd_lmr), .cmd_bst(cmd_bst),
    .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .bank_open(bank_open),
    .pwr_mode(pwr_mode), .illegal(illegal)
);

// File: tb/sim_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module sim_sdram_cmd_tracker;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dqm = 1'b0;
    logic [1:0] ba = '0;
    logic [10:0] addr = '0;
    logic cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_lmr, cmd_bst, cmd_ap;
    logic [1:0] cmd_bank, pwr_mode;
    logic [7:0] cmd_col;
    logic [3:0] bank_open;
    logic [43:0] open_rows;
    logic [10:0] mode_reg, ext_mode_reg;
    logic wr_mask, rd_oe, illegal;

    always #2.5 clk = ~clk;

    sdram_cmd_tracker u0 (.*);

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // reference model state
    logic [3:0]  m_open;
    logic [43:0] m_rows;
    logic [10:0] m_mode, m_ext;
    logic        m_ill, m_d1, m_d2, m_ap;
    logic [1:0]  m_pm, m_bank;
    logic [7:0]  m_col;
    logic [6:0]  m_stb;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R1 strobes", 64'({cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_lmr, cmd_bst}), 64'(m_stb));
        chk("R1 fields", 64'({cmd_bank, cmd_col, cmd_ap}), 64'({m_bank, m_col, m_ap}));
        chk("R4 R5 R11 bank_open", 64'(bank_open), 64'(m_open));
        chk("R3 rows", 64'(open_rows), 64'(m_rows));
        chk("R6 mode regs", 64'({mode_reg, ext_mode_reg}), 64'({m_mode, m_ext}));
        chk("R7 wr_mask", 64'(wr_mask), 64'(dqm));
        chk("R8 rd_oe", 64'(rd_oe),
            64'((m_ext[0] && m_mode[6:4] == 3'd1) ? m_d1 : m_d2));
        chk("R9 R10 pwr_mode", 64'(pwr_mode), 64'(m_pm));
        chk("R11 R13 illegal", 64'(illegal), 64'(m_ill));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; dqm = 1'b0;
        {ras_n, cas_n, we_n} = 3'b111;
        repeat (3) @(posedge clk);
        #1;
        m_open = '0; m_rows = '0; m_mode = '0; m_ext = '0; m_ill = 0;
        m_d1 = 0; m_d2 = 0; m_pm = 0; m_bank = 0; m_col = 0; m_ap = 0; m_stb = '0;
        compare_all();  // R13 reset state
        rst_n = 1'b1;
    endtask

    task automatic step(input logic k, input logic c, input logic [2:0] op,
                        input logic [1:0] b, input logic [10:0] a, input logic m);
        logic [3:0]  n_open = m_open;
        logic [43:0] n_rows = m_rows;
        logic [10:0] n_mode = m_mode, n_ext = m_ext;
        logic        n_ill = m_ill, ok = 0;
        logic [1:0]  n_pm = m_pm;
        logic        nop = c || (op == 3'b111);
        m_stb = '0;
        if (m_pm == 2'd0) begin
            if (k && !c) begin
                case (op)
                    3'b011: if (m_open[b]) n_ill = 1; else begin
                                ok = 1; n_open[b] = 1; n_rows[b*11 +: 11] = a; m_stb[6] = 1; end
                    3'b101, 3'b100: if (!m_open[b]) n_ill = 1; else begin
                                ok = 1; if (a[8]) n_open[b] = 0;
                                if (op == 3'b101) m_stb[5] = 1; else m_stb[4] = 1; end
                    3'b010: begin ok = 1; m_stb[3] = 1;
                                if (a[8]) n_open = '0; else n_open[b] = 0; end
                    3'b001: if (m_open != 0) n_ill = 1; else begin ok = 1; m_stb[2] = 1; end
                    3'b000: begin ok = 1; m_stb[1] = 1;
                                if (b == 0) n_mode = a; if (b == 1) n_ext = a; end
                    3'b110: begin ok = 1; m_stb[0] = 1; end
                    default: ;
                endcase
                if (ok && op != 3'b111) begin m_bank = b; m_col = a[7:0]; m_ap = a[8]; end
            end else if (!k) begin
                if (nop) n_pm = (m_open == 0) ? 2'd1 : 2'd2;
                else if (op == 3'b001) begin
                    n_pm = (m_open == 0) ? 2'd3 : 2'd2;
                    if (m_open != 0) n_ill = 1;
                end else n_pm = 2'd2;
            end
        end else if (k) begin
            n_pm = 2'd0;
            if (!nop) n_ill = 1;
        end
        cke = k; cs_n = c; {ras_n, cas_n, we_n} = op; ba = b; addr = a; dqm = m;
        @(posedge clk);
        #1;
        m_open = n_open; m_rows = n_rows; m_mode = n_mode; m_ext = n_ext;
        m_ill = n_ill; m_pm = n_pm; m_d2 = m_d1; m_d1 = !m;
        compare_all();
    endtask

    localparam logic [2:0] OP_ACT = 3'b011, OP_RD = 3'b101, OP_WR = 3'b100,
        OP_PRE = 3'b010, OP_REF = 3'b001, OP_LMR = 3'b000, OP_NOP = 3'b111;

    initial begin
        void'($urandom(32'h5D1A_0C3E));
        do_reset();
        // R6 mode load: CL=1, then extended option bit 0
        step(1, 0, OP_LMR, 2'd0, 11'h010, 0);
        step(1, 0, OP_LMR, 2'd1, 11'h001, 0);
        step(1, 0, OP_LMR, 2'd2, 11'h7FF, 0);
        chk("R6 ba2 no effect", 64'({mode_reg, ext_mode_reg}), 64'({11'h010, 11'h001}));
        // R8 one-cycle path
        step(1, 1, OP_NOP, 0, 0, 1);
        chk("R8 fast dqm high", 64'(rd_oe), 64'(0));
        step(1, 1, OP_NOP, 0, 0, 0);
        chk("R8 fast dqm low", 64'(rd_oe), 64'(1));
        // R3 R4 activate, read, write with auto-precharge
        step(1, 0, OP_ACT, 2'd2, 11'h5A5, 0);
        chk("R3 row latched", 64'(open_rows[22 +: 11]), 64'(11'h5A5));
        step(1, 0, OP_RD, 2'd2, 11'h033, 0);
        chk("R4 read strobe", 64'({cmd_rd, cmd_col}), 64'({1'b1, 8'h33}));
        step(1, 0, OP_WR, 2'd2, 11'h1C4, 1);
        chk("R4 auto precharge", 64'(bank_open[2]), 64'(0));
        // R2 deselect with activate code
        step(1, 1, OP_ACT, 2'd1, 11'h123, 0);
        chk("R2 deselect ignored", 64'({cmd_act, bank_open}), 64'(0));
        // R11 read to closed bank
        step(1, 0, OP_RD, 2'd2, 11'h000, 0);
        chk("R11 closed read flagged", 64'({illegal, cmd_rd}), 64'({1'b1, 1'b0}));

        do_reset();
        step(1, 0, OP_ACT, 2'd0, 11'h111, 0);
        step(1, 0, OP_ACT, 2'd1, 11'h222, 0);
        step(1, 0, OP_REF, 2'd0, 11'h000, 0);
        chk("R12 refresh with open bank", 64'({illegal, cmd_ref}), 64'({1'b1, 1'b0}));
        step(1, 0, OP_PRE, 2'd0, 11'h000, 0);
        chk("R5 single precharge", 64'(bank_open), 64'(4'b0010));
        step(1, 0, OP_PRE, 2'd3, 11'h100, 0);
        chk("R5 precharge all", 64'(bank_open), 64'(0));
        step(1, 0, OP_REF, 2'd0, 11'h000, 0);
        chk("R12 refresh idle", 64'(cmd_ref), 64'(1));
        step(1, 1, OP_NOP, 0, 0, 0);
        chk("R13 illegal sticky", 64'(illegal), 64'(1));

        do_reset();
        step(0, 1, OP_NOP, 0, 0, 0);
        chk("R9 power-down", 64'(pwr_mode), 64'(1));
        step(0, 0, OP_ACT, 2'd3, 11'h0AA, 0);
        chk("R10 ignored in low power", 64'({cmd_act, bank_open}), 64'(0));
        step(1, 1, OP_NOP, 0, 0, 0);
        chk("R10 exit", 64'({pwr_mode, illegal}), 64'(0));
        step(1, 0, OP_ACT, 2'd3, 11'h0AA, 0);
        step(0, 1, OP_NOP, 0, 0, 0);
        chk("R9 suspend", 64'(pwr_mode), 64'(2));
        step(1, 0, OP_RD, 2'd3, 0, 0);
        chk("R10 bad exit", 64'({pwr_mode, illegal, cmd_rd}), 64'({2'd0, 1'b1, 1'b0}));

        do_reset();
        step(0, 0, OP_REF, 0, 0, 0);
        chk("R9 self refresh", 64'(pwr_mode), 64'(3));
        step(1, 1, OP_NOP, 0, 0, 0);
        chk("R10 self refresh exit", 64'({pwr_mode, illegal}), 64'(0));
        chk("R8 slow default", 64'(rd_oe), 64'(1));

        for (int i = 0; i < 4000; i++) begin
            if (i % 400 == 0) begin
                do_reset();
                step(1, 0, OP_LMR, 2'd0, ($urandom % 2) ? 11'h010 : 11'h020, 0);
                step(1, 0, OP_LMR, 2'd1, 11'($urandom % 2), 0);
            end
            step(($urandom % 12) != 0, ($urandom % 8) == 0, 3'($urandom),
                 2'($urandom), 11'($urandom), 1'($urandom));
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule